// File: doc/BRIEF.md
# Address pipeline depth controller

This block sits beside the address-phase logic of a split-transaction processor bus and limits how far address tenures may run ahead of data tenures. It watches transfer starts, address acknowledges and the start and end of each data tenure. From these it produces a permission signal that tells the address slave when it may acknowledge the pending address. It also produces an inhibit that forces every address bus grant off.

Two pipeline policies are available. With no pipelining, a data-bearing address is acknowledged only after its own data tenure has finished. With one-level pipelining, an address may be acknowledged while no other data tenure is running and no earlier acknowledged address is still waiting for its data. Slaves in compatibility mode may acknowledge regardless of the permission. For that case the block counts acknowledged addresses whose data tenure has not yet begun. When that count reaches two, the block blocks all further address grants.

The policy setting is sampled only while the bus is idle, so a change never takes effect in the middle of a transaction.

Top module: `pdc_pipe_ctrl`

## Requirements
- R1: After reset, `aack_en_o` and `bg_inhibit_o` are 0, `depth_o` is 0, and the policy is no-pipelining (`pipe_mode_i` value 0).
- R2: With no pipelining, `aack_en_o` for a data-bearing address (`addr_only_i`=0 at the transfer start) stays 0 until its data tenure ends. It becomes 1 in the cycle after the cycle in which `dend_i` is high.
- R3: With no pipelining, an address-only transfer gets `aack_en_o`=1 in the cycle after its transfer start when no data tenure is running and `depth_o` is 0.
- R4: With one-level pipelining (`pipe_mode_i`=1), `aack_en_o` rises in the cycle after a transfer start when no data tenure is running and `depth_o` is 0.
- R5: With one-level pipelining, an address that arrives while an earlier acknowledged address is unserved, or while another data tenure runs, keeps `aack_en_o`=0 until that tenure ends. `aack_en_o` then rises in the cycle after `dend_i`.
- R6: An accepted acknowledge of a data-bearing address whose data tenure has not started raises `depth_o` by one in the next cycle. A data tenure start while `depth_o` is nonzero lowers it by one. The count saturates at 2.
- R7: An accepted acknowledge of an address-only transfer leaves `depth_o` unchanged.
- R8: `bg_inhibit_o` is 1 exactly while `depth_o` equals 2. It falls in the cycle after a data tenure start that lowers the count.
- R9: With `compat_i`=1, an acknowledge on `aack_i` is accepted even while `aack_en_o` is 0. With `compat_i`=0, such an acknowledge is ignored: the count stays the same and the address stays pending.
- R10: `pipe_mode_i` is sampled only in cycles with no pending address, no running data tenure and `depth_o`=0. A change made while a transaction is open takes effect only after the bus goes idle.
- R11: After an accepted acknowledge, `aack_en_o` is 0 in the next cycle until a new transfer start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ts_i | input | 1 | Transfer start of a new address tenure |
| addr_only_i | input | 1 | Qualifies `ts_i`: 1 means the transfer has no data tenure |
| aack_i | input | 1 | Address acknowledge seen on the bus |
| dstart_i | input | 1 | First cycle of a data tenure |
| dend_i | input | 1 | Last cycle of a data tenure |
| pipe_mode_i | input | 1 | Policy request: 0 no pipelining, 1 one-level pipelining |
| compat_i | input | 1 | 1 when slaves may acknowledge without permission |
| aack_en_o | output | 1 | Permission to acknowledge the pending address |
| bg_inhibit_o | output | 1 | Forces all address bus grants off |
| depth_o | output | 2 | Acknowledged addresses still waiting for their data tenure |

## Verification
The assertions assume a well-formed bus:
- a transfer start comes only when no address is pending;
- `dstart_i` comes only while no data tenure runs;
- `dend_i` comes only while one runs, and at least one cycle after its start;
- without compatibility mode, a slave acknowledges only when permitted.

The bench keeps to these rules by driving single-cycle pulses on separate cycles, with every data tenure two or more cycles long. The only acknowledges it forces without permission are the ones that test R9, and for these the ignore property is checked at the ports.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic {
    MODE_NOPIPE   = 1'b0,
    MODE_ONELEVEL = 1'b1
  } pipe_mode_e;

endpackage

// File: rtl/pdc_depth_cnt.sv
module pdc_depth_cnt #(
  parameter int MAX_DEPTH = 2,
  localparam int CNT_W = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] depth_o,
  output logic             zero_o,
  output logic             at_max_o
);

  localparam logic [CNT_W-1:0] TOP = CNT_W'(MAX_DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign at_max_o = (cnt_q == TOP);
  assign zero_o   = (cnt_q == '0);
  assign depth_o  = cnt_q;
  assign cnt_en   = inc_i ^ dec_i;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i && !dec_i && !at_max_o) begin
      cnt_d = cnt_q + 1'b1;
    end else if (dec_i && !inc_i && !zero_o) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R6: the count moves by at most one step per cycle
  assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt_q) == int'($past(cnt_q)) || int'(cnt_q) == int'($past(cnt_q)) + 1 ||
     int'(cnt_q) + 1 == int'($past(cnt_q))));

  // R8: the inhibit level is left only after a data tenure start
  assert_inhibit_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(at_max_o) |-> $past(dec_i));

  // R8: the inhibit level is reached only through an acknowledge
  assert_inhibit_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(at_max_o) |-> $past(inc_i));

endmodule

// File: rtl/pdc_tenure_track.sv
module pdc_tenure_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ts_i,
  input  logic addr_only_i,
  input  logic aack_acc_i,
  input  logic dstart_i,
  input  logic dend_i,
  input  logic depth_zero_i,
  output logic addr_pend_o,
  output logic cur_data_o,
  output logic cur_started_o,
  output logic cur_done_o,
  output logic data_busy_o,
  output logic start_for_cur_o
);

  logic pend_q, pend_d;
  logic data_q, data_d;
  logic started_q, started_d;
  logic done_q, done_d;
  logic busy_q, busy_d;
  logic cand_data;
  logic trk_en;

  // A data tenure belongs to the current address when no older one waits
  assign cand_data       = ts_i ? !addr_only_i : (pend_q && data_q && !started_q);
  assign start_for_cur_o = dstart_i && depth_zero_i && cand_data;
  assign trk_en          = ts_i | aack_acc_i | dstart_i | dend_i;

  always_comb begin
    pend_d    = pend_q;
    data_d    = data_q;
    started_d = started_q;
    done_d    = done_q;
    busy_d    = busy_q;
    if (ts_i) begin
      pend_d    = 1'b1;
      data_d    = !addr_only_i;
      started_d = 1'b0;
      done_d    = 1'b0;
    end else if (aack_acc_i) begin
      pend_d = 1'b0;
    end
    if (start_for_cur_o) begin
      started_d = 1'b1;
    end
    if (dend_i && started_q && !ts_i) begin
      done_d = 1'b1;
    end
    if (dstart_i) begin
      busy_d = 1'b1;
    end else if (dend_i) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      data_q    <= 1'b0;
      started_q <= 1'b0;
      done_q    <= 1'b0;
      busy_q    <= 1'b0;
    end else if (trk_en) begin
      pend_q    <= pend_d;
      data_q    <= data_d;
      started_q <= started_d;
      done_q    <= done_d;
      busy_q    <= busy_d;
    end
  end

  assign addr_pend_o   = pend_q;
  assign cur_data_o    = data_q;
  assign cur_started_o = started_q;
  assign cur_done_o    = done_q;
  assign data_busy_o   = busy_q;

  // R2: a finished tenure is only ever recorded for an address that owns one
  assert_done_needs_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(dend_i) && data_q);

endmodule

// File: rtl/pdc_aack_policy.sv
module pdc_aack_policy
  import pdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pipe_mode_i,
  input  logic       idle_i,
  input  logic       addr_pend_i,
  input  logic       cur_data_i,
  input  logic       cur_started_i,
  input  logic       cur_done_i,
  input  logic       data_busy_i,
  input  logic       depth_zero_i,
  output pipe_mode_e mode_o,
  output logic       aack_en_o
);

  pipe_mode_e mode_q, mode_d;
  logic       mode_en;

  assign mode_en = idle_i;
  assign mode_d  = pipe_mode_e'(pipe_mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NOPIPE;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_comb begin
    aack_en_o = 1'b0;
    unique case (mode_q)
      MODE_NOPIPE: begin
        if (cur_data_i) begin
          aack_en_o = addr_pend_i && cur_done_i;
        end else begin
          aack_en_o = addr_pend_i && depth_zero_i && !data_busy_i;
        end
      end
      MODE_ONELEVEL: begin
        aack_en_o = addr_pend_i && depth_zero_i && (!data_busy_i || cur_started_i);
      end
      default: aack_en_o = 1'b0;
    endcase
  end

  assign mode_o = mode_q;

  // R10: the policy never changes while a data tenure runs
  assert_mode_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    data_busy_i |=> $stable(mode_q));

  // R5: no permission while a foreign data tenure occupies the bus
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    aack_en_o |-> (!data_busy_i || cur_started_i));

endmodule

// File: rtl/pdc_pipe_ctrl.sv
module pdc_pipe_ctrl
  import pdc_pkg::*;
#(
  parameter int INHIBIT_DEPTH = 2,
  parameter int SYNC_STAGES   = 2,
  localparam int CNT_W = $clog2(INHIBIT_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ts_i,
  input  logic             addr_only_i,
  input  logic             aack_i,
  input  logic             dstart_i,
  input  logic             dend_i,
  input  logic             pipe_mode_i,
  input  logic             compat_i,
  output logic             aack_en_o,
  output logic             bg_inhibit_o,
  output logic [CNT_W-1:0] depth_o
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[SYNC_STAGES-1];

  logic       addr_pend, cur_data, cur_started, cur_done, data_busy;
  logic       start_for_cur, depth_zero, at_max;
  logic       aack_acc, cnt_inc, cnt_dec, bus_idle;
  pipe_mode_e mode;

  assign aack_acc = aack_i && addr_pend && (compat_i || aack_en_o);
  assign cnt_inc  = aack_acc && cur_data && !cur_started && !start_for_cur;
  assign cnt_dec  = dstart_i && !depth_zero;
  assign bus_idle = !addr_pend && depth_zero && !data_busy;

  pdc_tenure_track u_track (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .ts_i           (ts_i),
    .addr_only_i    (addr_only_i),
    .aack_acc_i     (aack_acc),
    .dstart_i       (dstart_i),
    .dend_i         (dend_i),
    .depth_zero_i   (depth_zero),
    .addr_pend_o    (addr_pend),
    .cur_data_o     (cur_data),
    .cur_started_o  (cur_started),
    .cur_done_o     (cur_done),
    .data_busy_o    (data_busy),
    .start_for_cur_o(start_for_cur)
  );

  pdc_depth_cnt #(
    .MAX_DEPTH(INHIBIT_DEPTH)
  ) u_depth (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .inc_i   (cnt_inc),
    .dec_i   (cnt_dec),
    .depth_o (depth_o),
    .zero_o  (depth_zero),
    .at_max_o(at_max)
  );

  pdc_aack_policy u_policy (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .pipe_mode_i  (pipe_mode_i),
    .idle_i       (bus_idle),
    .addr_pend_i  (addr_pend),
    .cur_data_i   (cur_data),
    .cur_started_i(cur_started),
    .cur_done_i   (cur_done),
    .data_busy_i  (data_busy),
    .depth_zero_i (depth_zero),
    .mode_o       (mode),
    .aack_en_o    (aack_en_o)
  );

  assign bg_inhibit_o = at_max;

  // R2: without pipelining, permission for a data address follows its tenure end
  assert_nopipe_after_end_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(aack_en_o) && mode == MODE_NOPIPE && cur_data) |-> $past(dend_i));

  // R5: with one-level pipelining, permission appears after a start or a tenure end
  assert_pipe_release_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(aack_en_o) && mode == MODE_ONELEVEL) |-> $past(ts_i || dend_i));

  // R9: an unpermitted acknowledge without compatibility mode never raises the count
  assert_ignored_aack_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!compat_i && !aack_en_o && aack_i) |=> (depth_o <= $past(depth_o)));

  // R11: an accepted acknowledge consumes the permission
  assert_aack_consumed_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (aack_acc && !ts_i) |=> !aack_en_o);

  // R8: grants are never inhibited while an acknowledge is permitted
  assert_inhibit_excl_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    aack_en_o |-> !bg_inhibit_o);

endmodule

// File: tb/pdc_pipe_ctrl_tb.sv
module pdc_pipe_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ts, addr_only, aack, dstart, dend, pipe_mode, compat;
  logic       aack_en, bg_inh;
  logic [1:0] depth;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pdc_pipe_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ts_i        (ts),
    .addr_only_i (addr_only),
    .aack_i      (aack),
    .dstart_i    (dstart),
    .dend_i      (dend),
    .pipe_mode_i (pipe_mode),
    .compat_i    (compat),
    .aack_en_o   (aack_en),
    .bg_inhibit_o(bg_inh),
    .depth_o     (depth)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // one cycle with the given pulses, then all pulses back to 0
  task automatic cyc(input bit t, input bit ao, input bit ak, input bit ds, input bit de);
    ts = t; addr_only = ao; aack = ak; dstart = ds; dend = de;
    tick();
    ts = 0; addr_only = 0; aack = 0; dstart = 0; dend = 0;
  endtask

  // inhibit must mirror depth==2 at every sample (R8)
  task automatic chk_inh(input string tag);
    chk(tag, int'(bg_inh), (depth == 2'd2) ? 1 : 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ts = 0; addr_only = 0; aack = 0; dstart = 0; dend = 0;
    pipe_mode = 0; compat = 0;
    repeat (3) tick();
    chk("R1 aack_en in reset", int'(aack_en), 0);
    chk("R1 inhibit in reset", int'(bg_inh), 0);
    chk("R1 depth in reset", int'(depth), 0);
    @(negedge clk);
    rst_n = 1;
    repeat (4) tick();
    chk("R1 depth after reset", int'(depth), 0);
    chk("R1 aack_en after reset", int'(aack_en), 0);

    // R1 + R2: reset policy is no-pipelining; sweep tenure length and compat
    for (int cm = 0; cm < 2; cm++) begin
      for (int g = 0; g < 4; g++) begin
        compat = cm[0];
        cyc(1, 0, 0, 0, 0);
        chk("R1 no-pipe default holds ack", int'(aack_en), 0);
        cyc(0, 0, 0, 1, 0);
        chk("R2 held at data start", int'(aack_en), 0);
        for (int k = 0; k < g; k++) begin
          tick();
          chk("R2 held during tenure", int'(aack_en), 0);
        end
        cyc(0, 0, 0, 0, 1);
        chk("R2 enabled after end", int'(aack_en), 1);
        chk("R2 depth zero", int'(depth), 0);
        cyc(0, 0, 1, 0, 0);
        chk("R11 consumed", int'(aack_en), 0);
        chk("R6 late ack not counted", int'(depth), 0);
        tick();
      end
    end
    compat = 0;

    // R3: address-only with no pipelining
    cyc(1, 1, 0, 0, 0);
    chk("R3 address-only enabled", int'(aack_en), 1);
    cyc(0, 0, 1, 0, 0);
    chk("R3 consumed", int'(aack_en), 0);
    chk("R7 address-only ack", int'(depth), 0);
    tick();

    // R10: request one-level pipelining while an address is open
    cyc(1, 0, 0, 0, 0);
    pipe_mode = 1;
    tick();
    chk("R10 old policy still active", int'(aack_en), 0);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R10 old policy releases after end", int'(aack_en), 1);
    cyc(0, 0, 1, 0, 0);
    tick();
    cyc(1, 0, 0, 0, 0);
    chk("R10 new policy after idle", int'(aack_en), 1);
    cyc(0, 0, 1, 0, 0);
    chk("R6 counted", int'(depth), 1);
    cyc(0, 0, 0, 1, 0);
    chk("R6 drained", int'(depth), 0);
    cyc(0, 0, 0, 0, 1);
    tick();

    // R4 + R5 + R6: one-level pipelining sweep
    for (int cm = 0; cm < 2; cm++) begin
      for (int g = 0; g < 4; g++) begin
        compat = cm[0];
        cyc(1, 0, 0, 0, 0);
        chk("R4 immediate enable", int'(aack_en), 1);
        cyc(0, 0, 1, 0, 0);
        chk("R6 inc on early ack", int'(depth), 1);
        chk("R11 consumed", int'(aack_en), 0);
        chk_inh("R8 inhibit at depth 1");
        cyc(1, 0, 0, 0, 0);
        chk("R5 pipelined held", int'(aack_en), 0);
        cyc(0, 0, 0, 1, 0);
        chk("R6 dec on start", int'(depth), 0);
        chk("R5 held while tenure runs", int'(aack_en), 0);
        for (int k = 0; k < g; k++) begin
          tick();
          chk("R5 held during tenure", int'(aack_en), 0);
        end
        cyc(0, 0, 0, 0, 1);
        chk("R5 released after end", int'(aack_en), 1);
        cyc(0, 0, 1, 0, 0);
        chk("R6 second inc", int'(depth), 1);
        cyc(0, 0, 0, 1, 0);
        chk("R6 second dec", int'(depth), 0);
        cyc(0, 0, 0, 0, 1);
        tick();
      end
    end

    // R7: address-only in one-level mode
    compat = 0;
    cyc(1, 1, 0, 0, 0);
    chk("R4 address-only enable", int'(aack_en), 1);
    cyc(0, 0, 1, 0, 0);
    chk("R7 no count", int'(depth), 0);
    tick();

    // R8 + R9 + R6 saturation: compatibility mode reaches depth two
    compat = 1;
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R6 depth one", int'(depth), 1);
    cyc(1, 0, 0, 0, 0);
    chk("R5 second address held", int'(aack_en), 0);
    cyc(0, 0, 1, 0, 0);
    chk("R9 compat ack counted", int'(depth), 2);
    chk("R8 inhibit at two", int'(bg_inh), 1);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R8 inhibit held", int'(bg_inh), 1);
    end
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R6 saturates", int'(depth), 2);
    chk_inh("R8 saturated inhibit");
    cyc(0, 0, 0, 1, 0);
    chk("R6 dec from two", int'(depth), 1);
    chk("R8 release after start", int'(bg_inh), 0);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 1, 0);
    chk("R6 back to zero", int'(depth), 0);
    cyc(0, 0, 0, 0, 1);
    tick();

    // R9: unpermitted acknowledge ignored without compatibility mode
    compat = 0;
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R6 depth one again", int'(depth), 1);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R9 ignored ack no count", int'(depth), 1);
    chk("R9 no inhibit", int'(bg_inh), 0);
    cyc(0, 0, 0, 1, 0);
    chk("R9 still held", int'(aack_en), 0);
    cyc(0, 0, 0, 0, 1);
    chk("R9 address still pending", int'(aack_en), 1);
    cyc(0, 0, 1, 0, 0);
    chk("R9 real ack counted", int'(depth), 1);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R6 idle at end", int'(depth), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule